// File: doc/BRIEF.md
# DRAM Read Calibration Pattern Sequencer

This block sits on the controller side of a DDR3 interface and runs the read-timing calibration loop that uses the memory's built-in training pattern. A start request begins the sequence. The block first closes every bank with a precharge-all command. It then writes mode register 3 so that reads return the fixed training pattern rather than array data. After that it issues fixed-order BL8 reads, one after another, and compares every returned beat against the alternating zero/one pattern. A capture-quality input from the PHY tuning logic decides after each burst whether the loop goes on. When the loop ends, the block writes mode register 3 again to return the device to normal operation. It reports completion only once the settling windows after that write have run out.

Every wait between steps is a down-counter loaded from a runtime timing input: precharge recovery, mode-register command spacing, mode-register update delay, pattern-read recovery, and additive plus CAS latency. An iteration ceiling stops a loop that never converges and flags it. A sticky flag records any beat that did not match the pattern.

Top module: `calib_pattern_seq`

## Requirements
- R1: While reset is held, and in the idle state after it, `cmd_o` is NOP (code 0), `done_o`, `err_o`, `limit_o` and `mpr_active_o` are 0, and `cmd_ok_o` is 1.
- R2: When `start_i` is sampled high in idle, the next cycle carries a precharge-all command (code 1) with `ba_o`=0 and only address bit 10 set.
- R3: The entry mode write (code 2) has `ba_o`=3 and `addr_o`=0x0004, so bit 2 is set and bits 1:0 are 00. It comes exactly max(t_rp,2) cycles after the precharge-all.
- R4: The first read (code 3) comes exactly max(max(t_mrd,t_mod),2) cycles after the entry mode write. Every read carries `ba_o`=0 and `addr_o`=0x1000: bit 12 set for BL8, bits 2:0 zero for the fixed order starting at beat 0.
- R5: The 8 beats of a burst are sampled on the consecutive cycles that start max(al+cl,2) cycles after the read. Beat k is expected to have every data bit equal to k mod 2. Any mismatching bit sets `err_o` on the following cycle, and `err_o` stays set until the next accepted start.
- R6: The decision is taken in the cycle of the last beat. If `capture_ok_i` is low and the limit is not reached, the next read follows in the very next cycle, so reads are spaced max(al+cl,2)+8 cycles apart. Otherwise the exit mode write (`ba_o`=3, `addr_o`=0) follows exactly max(t_mprr,2) cycles after the last-beat cycle.
- R7: `done_o` is a single-cycle pulse exactly max(max(t_mrd,t_mod),2) cycles after the exit mode write. At that point `iter_o` holds the number of completed bursts, and it keeps that value until the next start.
- R8: `cmd_ok_o` is 0 from the precharge-all cycle until the cycle before `done_o`, and it is 1 in the done cycle and in idle. No command other than NOP is issued while it is 1.
- R9: `mpr_active_o` is 1 from the entry mode write cycle through the exit mode write cycle inclusive, and 0 otherwise. Only NOP, precharge-all, mode write and read are ever issued, and a read is issued only while `mpr_active_o` is 1.
- R10: `start_i` has no effect while a sequence is in progress. Exactly one precharge-all is issued per accepted start.
- R11: After a burst completes, if `capture_ok_i` is low and the completed count is at least `max_iter_i`, the loop ends through the normal exit and `limit_o` is set (sticky until the next start). A `capture_ok_i` arriving in that same cycle takes priority, and `limit_o` stays 0. A ceiling of 0 stops after one burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted in idle only |
| t_rp_i | input | TW | Precharge recovery count |
| t_mrd_i | input | TW | Mode-register command spacing count |
| t_mod_i | input | TW | Mode-register update delay count |
| t_mprr_i | input | TW | Pattern-read recovery count |
| al_i | input | LW | Additive latency |
| cl_i | input | LW | CAS latency |
| max_iter_i | input | IW | Iteration ceiling |
| rdata_i | input | DQ_W | Captured read data, one beat per cycle |
| capture_ok_i | input | 1 | Capture judged optimal, sampled on the last beat |
| cmd_o | output | 2 | Command: 0 NOP, 1 precharge-all, 2 mode write, 3 read |
| ba_o | output | BW | Bank address / mode register select |
| addr_o | output | AW | Address bus |
| mpr_active_o | output | 1 | Pattern mode in effect |
| cmd_ok_o | output | 1 | Regular commands permitted |
| done_o | output | 1 | Sequence complete pulse |
| iter_o | output | IW | Completed burst count |
| err_o | output | 1 | Sticky beat mismatch flag |
| limit_o | output | 1 | Sticky iteration-ceiling abort flag |

## Verification
Two events can land in the same cycle, the last beat of a burst: the capture-quality verdict and the iteration ceiling being reached. The bench sets a ceiling of two and raises `capture_ok_i` exactly on the final beat of the second burst. It expects a clean exit with `limit_o` low and a count of two, and it compares this with a run where the verdict never arrives and `limit_o` must rise. A mismatch injected on an inner beat is checked the same way, against a run with no error and against the clearing of the flag on the next start.

// File: rtl/calib_pkg.sv
package calib_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PREA = 2'd1,
    CMD_MRS  = 2'd2,
    CMD_READ = 2'd3
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_W_RP,
    ST_MRS_IN,
    ST_W_IN,
    ST_RD,
    ST_W_RL,
    ST_BURST,
    ST_W_MPRR,
    ST_MRS_OUT,
    ST_W_OUT,
    ST_DONE
  } seq_state_e;

  localparam int MR3_SEL    = 3;
  localparam int PAT_EN_BIT = 2;
  localparam int PREA_BIT   = 10;
  localparam int BL8_BIT    = 12;
  localparam int BURST_LEN  = 8;

endpackage

// File: rtl/calib_wait_timer.sv
// Down-counter; expire_o rises when the count reaches 2, so a wait state
// entered the cycle after load leaves max(val,2) cycles after the load.
module calib_wait_timer #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign expire_o = (cnt_q <= W'(2));
endmodule

// File: rtl/calib_burst_check.sv
module calib_burst_check #(
  parameter int DQ_W = 8,
  parameter int BL   = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            active_i,
  input  logic [DQ_W-1:0] rdata_i,
  output logic            last_o,
  output logic            mismatch_o
);
  localparam int BEAT_W = $clog2(BL);

  logic [BEAT_W-1:0] beat_q;
  logic [DQ_W-1:0]   lane_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        beat_q <= '0;
    else if (!active_i) beat_q <= '0;
    else                beat_q <= beat_q + BEAT_W'(1);
  end

  // expected pattern: even beats all zero, odd beats all one
  for (genvar i = 0; i < DQ_W; i++) begin : g_lane
    assign lane_bad[i] = rdata_i[i] ^ beat_q[0];
  end

  assign last_o     = active_i && (beat_q == BEAT_W'(BL - 1));
  assign mismatch_o = active_i && (|lane_bad);
endmodule

// File: rtl/calib_pattern_seq.sv
module calib_pattern_seq
  import calib_pkg::*;
#(
  parameter int TW   = 8,
  parameter int LW   = 5,
  parameter int IW   = 8,
  parameter int DQ_W = 8,
  parameter int AW   = 14,
  parameter int BW   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [TW-1:0]   t_rp_i,
  input  logic [TW-1:0]   t_mrd_i,
  input  logic [TW-1:0]   t_mod_i,
  input  logic [TW-1:0]   t_mprr_i,
  input  logic [LW-1:0]   al_i,
  input  logic [LW-1:0]   cl_i,
  input  logic [IW-1:0]   max_iter_i,
  input  logic [DQ_W-1:0] rdata_i,
  input  logic            capture_ok_i,
  output logic [1:0]      cmd_o,
  output logic [BW-1:0]   ba_o,
  output logic [AW-1:0]   addr_o,
  output logic            mpr_active_o,
  output logic            cmd_ok_o,
  output logic            done_o,
  output logic [IW-1:0]   iter_o,
  output logic            err_o,
  output logic            limit_o
);
  localparam int CW = ((TW > LW) ? TW : LW) + 1;

  seq_state_e st_q, st_d;
  cmd_e       cmd;
  logic          tmr_ld, tmr_go;
  logic [CW-1:0] tmr_val, mode_gap, rd_lat;
  logic          beat_last, beat_bad;
  logic [IW-1:0] iter_q, iter_nx;
  logic          err_q, lim_q;
  logic          start_acc, exit_now;

  assign start_acc = start_i && (st_q == ST_IDLE);
  assign iter_nx   = iter_q + IW'(1);
  assign exit_now  = capture_ok_i || (iter_nx >= max_iter_i);
  assign mode_gap  = (t_mrd_i > t_mod_i) ? CW'(t_mrd_i) : CW'(t_mod_i);
  assign rd_lat    = CW'(al_i) + CW'(cl_i);

  calib_wait_timer #(.W(CW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_ld),
    .val_i    (tmr_val),
    .expire_o (tmr_go)
  );

  calib_burst_check #(.DQ_W(DQ_W), .BL(BURST_LEN)) u_check (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (st_q == ST_BURST),
    .rdata_i    (rdata_i),
    .last_o     (beat_last),
    .mismatch_o (beat_bad)
  );

  always_comb begin
    tmr_ld  = 1'b0;
    tmr_val = '0;
    unique case (st_q)
      ST_PRE:                begin tmr_ld = 1'b1; tmr_val = CW'(t_rp_i); end
      ST_MRS_IN, ST_MRS_OUT: begin tmr_ld = 1'b1; tmr_val = mode_gap;    end
      ST_RD:                 begin tmr_ld = 1'b1; tmr_val = rd_lat;      end
      ST_BURST:              begin tmr_ld = beat_last && exit_now; tmr_val = CW'(t_mprr_i); end
      default: ;
    endcase
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (start_i) st_d = ST_PRE;
      ST_PRE:     st_d = ST_W_RP;
      ST_W_RP:    if (tmr_go) st_d = ST_MRS_IN;
      ST_MRS_IN:  st_d = ST_W_IN;
      ST_W_IN:    if (tmr_go) st_d = ST_RD;
      ST_RD:      st_d = ST_W_RL;
      ST_W_RL:    if (tmr_go) st_d = ST_BURST;
      ST_BURST:   if (beat_last) st_d = exit_now ? ST_W_MPRR : ST_RD;
      ST_W_MPRR:  if (tmr_go) st_d = ST_MRS_OUT;
      ST_MRS_OUT: st_d = ST_W_OUT;
      ST_W_OUT:   if (tmr_go) st_d = ST_DONE;
      ST_DONE:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      iter_q <= '0;
      err_q  <= 1'b0;
      lim_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start_acc) begin
        iter_q <= '0;
        err_q  <= 1'b0;
        lim_q  <= 1'b0;
      end else begin
        if (beat_bad) err_q <= 1'b1;
        if (beat_last) begin
          iter_q <= iter_nx;
          if (!capture_ok_i && (iter_nx >= max_iter_i)) lim_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    cmd    = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    unique case (st_q)
      ST_PRE:     begin cmd = CMD_PREA; addr_o[PREA_BIT] = 1'b1; end
      ST_MRS_IN:  begin cmd = CMD_MRS; ba_o = BW'(MR3_SEL); addr_o[PAT_EN_BIT] = 1'b1; end
      ST_MRS_OUT: begin cmd = CMD_MRS; ba_o = BW'(MR3_SEL); end
      ST_RD:      begin cmd = CMD_READ; addr_o[BL8_BIT] = 1'b1; end
      default: ;
    endcase
  end

  assign cmd_o        = cmd;
  assign mpr_active_o = (st_q == ST_MRS_IN) || (st_q == ST_W_IN) || (st_q == ST_RD) ||
                        (st_q == ST_W_RL) || (st_q == ST_BURST) || (st_q == ST_W_MPRR) ||
                        (st_q == ST_MRS_OUT);
  assign cmd_ok_o     = (st_q == ST_IDLE) || (st_q == ST_DONE);
  assign done_o       = (st_q == ST_DONE);
  assign iter_o       = iter_q;
  assign err_o        = err_q;
  assign limit_o      = lim_q;
endmodule

// File: rtl/calib_pattern_seq_chk.sv
module calib_pattern_seq_chk
  import calib_pkg::*;
#(
  parameter int TW = 8,
  parameter int AW = 14,
  parameter int BW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    cmd_o,
  input logic [BW-1:0] ba_o,
  input logic [AW-1:0] addr_o,
  input logic          mpr_active_o,
  input logic          cmd_ok_o,
  input logic          done_o,
  input logic [TW-1:0] t_rp_i,
  input logic [TW-1:0] t_mrd_i,
  input logic [TW-1:0] t_mod_i
);
  localparam int SW = 16;

  logic [SW-1:0] since_cmd, since_mrs;
  logic [TW-1:0] gap_mode;

  assign gap_mode = (t_mrd_i > t_mod_i) ? t_mrd_i : t_mod_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_cmd <= '0;
      since_mrs <= '0;
    end else begin
      if (cmd_o != CMD_NOP)     since_cmd <= SW'(1);
      else if (~&since_cmd)     since_cmd <= since_cmd + SW'(1);
      if (cmd_o == CMD_MRS)     since_mrs <= SW'(1);
      else if (~&since_mrs)     since_mrs <= since_mrs + SW'(1);
    end
  end

  assert_read_in_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_READ) |-> mpr_active_o) else $error("read outside pattern mode");

  assert_read_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_READ) |-> (ba_o == '0 && addr_o == (AW'(1) << BL8_BIT)))
    else $error("bad read address");

  assert_mode_write_sel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_MRS) |-> (ba_o == BW'(MR3_SEL) && addr_o[1:0] == 2'b00))
    else $error("bad mode write select");

  assert_trp_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_MRS && addr_o[PAT_EN_BIT]) |-> (since_cmd >= SW'(t_rp_i)))
    else $error("entry mode write before precharge recovery");

  assert_mode_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_READ) |-> (since_mrs >= SW'(gap_mode)))
    else $error("read before mode settle time");

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done wider than one cycle");

  assert_quiet_when_ok_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ok_o |-> (cmd_o == CMD_NOP)) else $error("command while regular access allowed");

  assert_done_ok_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cmd_ok_o && !mpr_active_o)) else $error("done with mode still active");
endmodule

bind calib_pattern_seq calib_pattern_seq_chk #(.TW(TW), .AW(AW), .BW(BW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_o        (cmd_o),
  .ba_o         (ba_o),
  .addr_o       (addr_o),
  .mpr_active_o (mpr_active_o),
  .cmd_ok_o     (cmd_ok_o),
  .done_o       (done_o),
  .t_rp_i       (t_rp_i),
  .t_mrd_i      (t_mrd_i),
  .t_mod_i      (t_mod_i)
);

// File: tb/calib_pattern_seq_test.sv
module calib_pattern_seq_test;
  localparam int TW = 8, LW = 5, IW = 8, DQ_W = 8, AW = 14, BW = 3;

  logic clk, rst_n, start_i, capture_ok_i;
  logic [TW-1:0] t_rp_i, t_mrd_i, t_mod_i, t_mprr_i;
  logic [LW-1:0] al_i, cl_i;
  logic [IW-1:0] max_iter_i;
  logic [DQ_W-1:0] rdata_i;
  logic [1:0] cmd_o;
  logic [BW-1:0] ba_o;
  logic [AW-1:0] addr_o;
  logic mpr_active_o, cmd_ok_o, done_o, err_o, limit_o;
  logic [IW-1:0] iter_o;

  calib_pattern_seq #(.TW(TW), .LW(LW), .IW(IW), .DQ_W(DQ_W), .AW(AW), .BW(BW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i),
    .t_rp_i(t_rp_i), .t_mrd_i(t_mrd_i), .t_mod_i(t_mod_i), .t_mprr_i(t_mprr_i),
    .al_i(al_i), .cl_i(cl_i), .max_iter_i(max_iter_i), .rdata_i(rdata_i),
    .capture_ok_i(capture_ok_i), .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o),
    .mpr_active_o(mpr_active_o), .cmd_ok_o(cmd_ok_o), .done_o(done_o),
    .iter_o(iter_o), .err_o(err_o), .limit_o(limit_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int tests = 0, fails = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int g2(input int n);
    return (n < 2) ? 2 : n;
  endfunction

  // read data responder
  int rl_b = 2, cap_burst = 0, bad_burst = 0, bad_beat = 0;
  logic [DQ_W-1:0] bad_mask = '0;
  int rd_num = 0, rd_cyc = 0;
  bit rd_pend = 0;

  always @(negedge clk) begin : resp
    int k;
    logic [DQ_W-1:0] v;
    logic cap;
    v = '0;
    cap = 1'b0;
    if (rd_pend) begin
      k = cyc - rd_cyc - rl_b;
      if (k >= 0 && k < 8) begin
        v = k[0] ? '1 : '0;
        if (rd_num == bad_burst && k == bad_beat) v = v ^ bad_mask;
        if (k == 7 && rd_num == cap_burst) cap = 1'b1;
      end
    end
    rdata_i = v;
    capture_ok_i = cap;
    if (cmd_o == 2'd3) begin
      rd_pend = 1;
      rd_cyc = cyc;
      rd_num++;
    end
  end

  // per-run observations
  int r_start_c, r_pre_n, r_pre_c, r_in_c, r_rd_n, r_rd_first, r_rd_last;
  int r_out_c, r_done_c, r_iter, r_err, r_lim;
  int r_rd_addr_bad, r_rd_gap_bad, r_ok_bad, r_mpr_bad, r_other_bad;
  int r_in_ok, r_out_ok, r_done_ok, r_pulse_ok, r_timeout;

  task automatic run_cal(input int trp, input int mrd, input int mod, input int mprr,
                         input int al, input int cl, input int maxit, input int cap_b,
                         input int bad_b, input int bad_k, input int restart_at);
    bit in_mode;
    int rd_gap;
    in_mode = 0;
    t_rp_i = TW'(trp); t_mrd_i = TW'(mrd); t_mod_i = TW'(mod); t_mprr_i = TW'(mprr);
    al_i = LW'(al); cl_i = LW'(cl); max_iter_i = IW'(maxit);
    rl_b = g2(al + cl); rd_gap = rl_b + 8;
    cap_burst = cap_b; bad_burst = bad_b; bad_beat = bad_k; bad_mask = 8'h04;
    rd_num = 0; rd_pend = 0;
    r_pre_n = 0; r_pre_c = -1; r_in_c = -1; r_rd_n = 0; r_rd_first = -1; r_rd_last = -1;
    r_out_c = -1; r_done_c = -1; r_rd_addr_bad = 0; r_rd_gap_bad = 0; r_ok_bad = 0;
    r_mpr_bad = 0; r_other_bad = 0; r_in_ok = 0; r_out_ok = 0; r_done_ok = 0;
    r_pulse_ok = 0; r_timeout = 1;
    @(negedge clk);
    start_i = 1'b1;
    r_start_c = cyc;
    @(negedge clk);
    start_i = 1'b0;
    for (int n = 0; n < 6000; n++) begin
      start_i = (restart_at > 0 && n == restart_at) ? 1'b1 : 1'b0;
      if (cmd_o == 2'd1) begin
        r_pre_n++;
        r_pre_c = cyc;
        if (!(ba_o == 3'd0 && addr_o == 14'h0400)) r_other_bad++;
      end else if (cmd_o == 2'd2 && addr_o[2]) begin
        r_in_c = cyc;
        r_in_ok = (ba_o == 3'd3 && addr_o == 14'h0004) ? 1 : 0;
        in_mode = 1;
      end else if (cmd_o == 2'd2) begin
        r_out_c = cyc;
        r_out_ok = (ba_o == 3'd3 && addr_o == 14'h0000) ? 1 : 0;
      end else if (cmd_o == 2'd3) begin
        if (r_rd_n > 0 && cyc - r_rd_last != rd_gap) r_rd_gap_bad++;
        if (r_rd_n == 0) r_rd_first = cyc;
        r_rd_last = cyc;
        r_rd_n++;
        if (!(ba_o == 3'd0 && addr_o == 14'h1000)) r_rd_addr_bad++;
      end else if (cmd_o != 2'd0) begin
        r_other_bad++;
      end
      if (mpr_active_o != in_mode) r_mpr_bad++;
      if (cmd_o == 2'd2 && !addr_o[2]) in_mode = 0;
      if (done_o) begin
        r_done_c = cyc;
        r_done_ok = cmd_ok_o ? 1 : 0;
        r_iter = int'(iter_o);
        r_err = int'(err_o);
        r_lim = int'(limit_o);
        r_timeout = 0;
        break;
      end else if (cmd_ok_o) begin
        r_ok_bad++;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    @(negedge clk);
    r_pulse_ok = (!done_o && cmd_ok_o && int'(iter_o) == r_iter) ? 1 : 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset;
    chk("R1", "reset cmd", int'(cmd_o), 0);
    chk("R1", "reset done/err/limit", int'({done_o, err_o, limit_o}), 0);
    chk("R1", "reset mpr_active", int'(mpr_active_o), 0);
    chk("R1", "reset cmd_ok", int'(cmd_ok_o), 1);
  endtask

  task automatic test_basic;
    run_cal(4, 3, 6, 5, 1, 5, 10, 3, 0, 0, 0);
    chk("R7", "basic completes", r_timeout, 0);
    chk("R2", "precharge one cycle after start", r_pre_c - r_start_c, 1);
    chk("R2", "precharge fields", r_other_bad, 0);
    chk("R3", "entry gap", r_in_c - r_pre_c, 4);
    chk("R3", "entry fields", r_in_ok, 1);
    chk("R4", "first read gap", r_rd_first - r_in_c, 6);
    chk("R4", "read fields", r_rd_addr_bad, 0);
    chk("R6", "read count", r_rd_n, 3);
    chk("R6", "read spacing", r_rd_gap_bad, 0);
    chk("R6", "exit gap from last beat", r_out_c - (r_rd_last + 6 + 7), 5);
    chk("R6", "exit fields", r_out_ok, 1);
    chk("R7", "done gap", r_done_c - r_out_c, 6);
    chk("R7", "iteration count", r_iter, 3);
    chk("R7", "done one cycle, count held", r_pulse_ok, 1);
    chk("R5", "no mismatch flagged", r_err, 0);
    chk("R11", "no limit", r_lim, 0);
    chk("R8", "cmd_ok low while busy", r_ok_bad, 0);
    chk("R8", "cmd_ok at done", r_done_ok, 1);
    chk("R9", "mpr_active window", r_mpr_bad, 0);
  endtask

  task automatic test_min_timing_mismatch;
    run_cal(0, 1, 0, 1, 0, 1, 5, 2, 1, 5, 0);
    chk("R3", "entry gap floor", r_in_c - r_pre_c, 2);
    chk("R4", "read gap floor", r_rd_first - r_in_c, 2);
    chk("R6", "read spacing floor", r_rd_gap_bad, 0);
    chk("R6", "exit gap floor", r_out_c - (r_rd_last + 2 + 7), 2);
    chk("R7", "done gap floor", r_done_c - r_out_c, 2);
    chk("R5", "mismatch on beat 5 flagged", r_err, 1);
    chk("R7", "count with mismatch", r_iter, 2);
    chk("R9", "mpr_active window short", r_mpr_bad, 0);
  endtask

  task automatic test_restart_ignored;
    run_cal(4, 3, 6, 5, 1, 5, 10, 2, 0, 0, 10);
    chk("R10", "single precharge", r_pre_n, 1);
    chk("R10", "run completes normally", r_iter, 2);
    chk("R5", "error cleared by start", r_err, 0);
    chk("R8", "cmd_ok low while busy", r_ok_bad, 0);
  endtask

  task automatic test_limit;
    run_cal(3, 2, 4, 3, 0, 6, 2, 0, 0, 0, 0);
    chk("R11", "limit abort reads", r_rd_n, 2);
    chk("R11", "limit flag", r_lim, 1);
    chk("R11", "limit count", r_iter, 2);
    chk("R6", "exit gap after abort", r_out_c - (r_rd_last + 6 + 7), 3);
    chk("R5", "no error on abort", r_err, 0);
  endtask

  task automatic test_tie;
    run_cal(3, 2, 4, 3, 0, 6, 2, 2, 0, 0, 0);
    chk("R11", "tie: capture wins", r_lim, 0);
    chk("R11", "tie count", r_iter, 2);
    chk("R6", "tie reads", r_rd_n, 2);
  endtask

  task automatic test_zero_limit;
    run_cal(3, 2, 4, 3, 0, 6, 0, 0, 0, 0, 0);
    chk("R11", "ceiling 0 single burst", r_rd_n, 1);
    chk("R11", "ceiling 0 flag", r_lim, 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0;
    t_rp_i = '0; t_mrd_i = '0; t_mod_i = '0; t_mprr_i = '0;
    al_i = '0; cl_i = '0; max_iter_i = '0;
    repeat (3) @(negedge clk);
    test_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset;
    test_basic;
    test_min_timing_mismatch;
    test_restart_ignored;
    test_limit;
    test_tie;
    test_zero_limit;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule